// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a segment-relative offset into a linear address for one cached segment. Software-side logic loads the segment's selector, base, 20-bit limit and granularity flag into the unit. After that, each request presents a 32-bit offset. One cycle later the unit answers with either a linear address or a fault carrying an error code.

A mode input picks between two formulas. The protected formula adds the cached base to the offset and checks the offset against the segment's effective limit. The limit check is inclusive, and the limit may be scaled to 4 KiB units. The legacy real formula shifts the 16-bit selector left by four bits and adds the offset, with no checks at all. A selector whose index field is zero marks a null segment. Loading a null selector is harmless, but any protected access through it faults with error code zero.

Internally a three-state machine holds the answer. ST_IDLE means no answer. ST_GRANT means an address is issued. ST_DENY means a fault is reported. From any state, a request whose check passes goes to ST_GRANT, a request whose check fails goes to ST_DENY, and a cycle with no request goes to ST_IDLE.

Top module: `seg_xlate_unit`

## Requirements
- R1: In protected mode (`real_mode_i`=0), a legal access returns `rsp_addr_o` = cached base + offset, wrapped modulo 2^32.
- R2: With granularity 0, an offset equal to the cached limit is legal, and an offset of limit+1 faults.
- R3: With granularity 1, the effective limit is limit*4096+4095. Offsets up to that value are legal, and the next offset faults. A limit of 0xFFFFF therefore admits offset 0xFFFFFFFF.
- R4: In real mode (`real_mode_i`=1), every request is granted with `rsp_addr_o` = (selector << 4) + offset modulo 2^32. This holds whatever the limit, the granularity, or a null selector.
- R5: A selector whose bits [15:3] are all zero is null. Loading it gives no fault. A protected access through it faults with `rsp_err_o` = 0.
- R6: A limit fault on a non-null selector reports `rsp_err_o` = selector with bits [1:0] cleared. While a fault is shown, `rsp_addr_o` is 0, so no address is issued.
- R7: Each request is answered exactly one cycle after it is sampled. `rsp_valid_o` and `rsp_fault_o` are never both high. A cycle without a request gives both low one cycle later. When `rsp_valid_o` is high, `rsp_err_o` is 0.
- R8: While `rst_n` is low, all response outputs are 0.
- R9: A segment load takes effect for requests sampled after the load edge. A request sampled in the same cycle as a load uses the previous segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| real_mode_i | input | 1 | 1 selects the real-mode formula for the request |
| seg_load_i | input | 1 | Load the segment fields below into the cache |
| seg_sel_i | input | 16 | Selector; bits [15:3] are the index |
| seg_base_i | input | 32 | Segment base |
| seg_limit_i | input | 20 | Segment limit |
| seg_gran_i | input | 1 | 1 scales the limit to 4 KiB units |
| req_valid_i | input | 1 | Request strobe |
| req_offset_i | input | 32 | Segment-relative offset |
| rsp_valid_o | output | 1 | Linear address issued |
| rsp_addr_o | output | 32 | Linear address (0 unless valid) |
| rsp_fault_o | output | 1 | Protection fault |
| rsp_err_o | output | 16 | Fault error code (0 unless fault) |

## Verification
A wrong state in the machine shows one cycle after the request. A stuck ST_GRANT raises valid with no request behind it, or issues an address where a fault is due. A stuck ST_DENY turns a legal access into a fault. A stale or corrupted segment cache shows as a wrong address or a wrong error code on the very next protected access. The corner cases that expose an off-by-one or a mis-scaled limit are the boundary offsets on either side of the effective limit, for both granularities.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int ADDR_W       = 32;
    localparam int LIMIT_W      = 20;
    localparam int SEL_W        = 16;
    localparam int GRAN_SHIFT   = ADDR_W - LIMIT_W;   // 4 KiB units
    localparam int REAL_SHIFT   = 4;
    localparam int RPL_W        = 2;
    localparam int IDX_LSB      = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [ADDR_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
        logic               gran;
    } seg_cache_t;
endpackage

// File: rtl/seg_shadow_reg.sv
module seg_shadow_reg
    import seg_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [LIMIT_W-1:0]  limit_i,
    input  logic                gran_i,
    output seg_cache_t          cache_o,
    output logic                null_o
);
    seg_cache_t cache_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cache_q <= '0;
        end else if (load_i) begin
            cache_q <= '{sel: sel_i, base: base_i, limit: limit_i, gran: gran_i};
        end
    end

    assign cache_o = cache_q;
    // index field all zero marks the null selector
    assign null_o  = (cache_q.sel[SEL_W-1:IDX_LSB] == '0);
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import seg_xlate_pkg::*;
(
    input  logic [LIMIT_W-1:0]  limit_i,
    input  logic                gran_i,
    input  logic [ADDR_W-1:0]   offset_i,
    output logic                in_range_o
);
    logic [ADDR_W-1:0] eff_limit;

    // scaled limit fills the low bits with ones so the compare stays inclusive
    always_comb begin
        if (gran_i) begin
            eff_limit = {limit_i, {GRAN_SHIFT{1'b1}}};
        end else begin
            eff_limit = ADDR_W'(limit_i);
        end
        in_range_o = (offset_i <= eff_limit);
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_xlate_pkg::*;
(
    input  logic                real_mode_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   offset_i,
    output logic [ADDR_W-1:0]   lin_o
);
    logic [ADDR_W-1:0] seg_origin;

    always_comb begin
        if (real_mode_i) begin
            seg_origin = ADDR_W'({sel_i, {REAL_SHIFT{1'b0}}});
        end else begin
            seg_origin = base_i;
        end
        lin_o = seg_origin + offset_i;   // wraps modulo 2^ADDR_W
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                real_mode_i,
    input  logic                seg_load_i,
    input  logic [15:0]         seg_sel_i,
    input  logic [31:0]         seg_base_i,
    input  logic [19:0]         seg_limit_i,
    input  logic                seg_gran_i,
    input  logic                req_valid_i,
    input  logic [31:0]         req_offset_i,
    output logic                rsp_valid_o,
    output logic [31:0]         rsp_addr_o,
    output logic                rsp_fault_o,
    output logic [15:0]         rsp_err_o
);
    localparam logic [SEL_W-1:0] RPL_CLR = ~SEL_W'((1 << RPL_W) - 1);

    seg_cache_t         cache;
    logic               seg_null;
    logic               in_range;
    logic [ADDR_W-1:0]  lin_addr;
    logic               access_ok;
    logic [SEL_W-1:0]   err_code;

    rsp_state_e         state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [SEL_W-1:0]   err_q;

    seg_shadow_reg u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (seg_load_i),
        .sel_i   (seg_sel_i),
        .base_i  (seg_base_i),
        .limit_i (seg_limit_i),
        .gran_i  (seg_gran_i),
        .cache_o (cache),
        .null_o  (seg_null)
    );

    seg_limit_chk u_limit (
        .limit_i    (cache.limit),
        .gran_i     (cache.gran),
        .offset_i   (req_offset_i),
        .in_range_o (in_range)
    );

    seg_addr_gen u_addr (
        .real_mode_i (real_mode_i),
        .sel_i       (cache.sel),
        .base_i      (cache.base),
        .offset_i    (req_offset_i),
        .lin_o       (lin_addr)
    );

    // real mode skips every check; protected needs a non-null, in-range access
    always_comb begin
        access_ok = real_mode_i || (!seg_null && in_range);
        err_code  = seg_null ? '0 : (cache.sel & RPL_CLR);
    end

    // next-state decision
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (req_valid_i) begin
                    state_d = access_ok ? ST_GRANT : ST_DENY;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register with its response payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= (state_d == ST_GRANT) ? lin_addr : '0;
            err_q   <= (state_d == ST_DENY)  ? err_code : '0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_fault_o = 1'b0;
        rsp_addr_o  = '0;
        rsp_err_o   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRANT: begin
                rsp_valid_o = 1'b1;
                rsp_addr_o  = addr_q;
            end
            ST_DENY: begin
                rsp_fault_o = 1'b1;
                rsp_err_o   = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         real_mode_i,
    input logic         seg_load_i,
    input logic [15:0]  seg_sel_i,
    input logic [31:0]  seg_base_i,
    input logic [19:0]  seg_limit_i,
    input logic         seg_gran_i,
    input logic         req_valid_i,
    input logic [31:0]  req_offset_i,
    input logic         rsp_valid_o,
    input logic [31:0]  rsp_addr_o,
    input logic         rsp_fault_o,
    input logic [15:0]  rsp_err_o
);
    logic [15:0] sel_s;
    logic [31:0] base_s;
    logic [19:0] lim_s;
    logic        gran_s;
    logic [32:0] span_s;
    logic        legal_s;
    logic        null_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_s  <= '0;
            base_s <= '0;
            lim_s  <= '0;
            gran_s <= 1'b0;
        end else if (seg_load_i) begin
            sel_s  <= seg_sel_i;
            base_s <= seg_base_i;
            lim_s  <= seg_limit_i;
            gran_s <= seg_gran_i;
        end
    end

    always_comb begin
        span_s  = gran_s ? ((33'(lim_s) + 33'd1) * 33'd4096) : (33'(lim_s) + 33'd1);
        legal_s = (33'(req_offset_i) < span_s);
        null_s  = (sel_s[15:3] == 13'd0);
    end

    // R7: valid and fault are exclusive
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid_o && rsp_fault_o));

    // R7: every request is answered on the next cycle
    p_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (rsp_valid_o || rsp_fault_o));

    // R7: no request, no answer
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !rsp_fault_o));

    // R1: legal protected access issues base plus offset
    p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !real_mode_i && !null_s && legal_s)
        |=> (rsp_valid_o && rsp_addr_o == $past(base_s + req_offset_i)));

    // R4: real mode never faults and uses the shifted selector
    p_real_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && real_mode_i)
        |=> (rsp_valid_o && rsp_addr_o == $past({12'd0, sel_s, 4'd0} + req_offset_i)));

    // R5: protected access through a null selector faults with code 0
    p_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !real_mode_i && null_s)
        |=> (rsp_fault_o && rsp_err_o == 16'd0));

    // R6: no address is issued alongside a fault
    p_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_o |-> (rsp_addr_o == 32'd0));
endmodule

bind seg_xlate_unit seg_xlate_chk u_seg_xlate_chk (.*);

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        real_mode_i, seg_load_i, seg_gran_i, req_valid_i;
    logic [15:0] seg_sel_i;
    logic [31:0] seg_base_i, req_offset_i;
    logic [19:0] seg_limit_i;
    logic        rsp_valid_o, rsp_fault_o;
    logic [31:0] rsp_addr_o;
    logic [15:0] rsp_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    seg_xlate_unit dut_i (.*);

    typedef struct {
        logic        v;
        logic        f;
        logic [31:0] a;
        logic [15:0] e;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // bench copy of the segment it loaded
    logic [15:0] m_sel = 0;
    logic [31:0] m_base = 0;
    logic [19:0] m_lim = 0;
    logic        m_gran = 0;

    function automatic exp_t predict(bit rm, logic [31:0] off, string tag);
        exp_t x;
        longint unsigned bytes;
        x.tag = tag; x.v = 0; x.f = 0; x.a = 0; x.e = 0;
        bytes = m_gran ? (longint'(m_lim) + 1) * 4096 : longint'(m_lim) + 1;
        if (rm) begin
            x.v = 1;
            x.a = 32'(longint'(m_sel) * 16 + longint'(off));
        end else if (m_sel[15:3] == 0) begin
            x.f = 1;                              // null: code 0
        end else if (longint'(off) < bytes) begin
            x.v = 1;
            x.a = 32'(longint'(m_base) + longint'(off));
        end else begin
            x.f = 1;
            x.e = {m_sel[15:2], 2'b00};
        end
        return x;
    endfunction

    function automatic exp_t quiet(string tag);
        exp_t x;
        x.tag = tag; x.v = 0; x.f = 0; x.a = 0; x.e = 0;
        return x;
    endfunction

    task automatic drive(bit ld, bit rq, bit rm, logic [31:0] off);
        seg_load_i   = ld;
        req_valid_i  = rq;
        real_mode_i  = rm;
        req_offset_i = off;
    endtask

    task automatic do_req(bit rm, logic [31:0] off, string tag);
        @(negedge clk);
        drive(0, 1, rm, off);
        sb_q.push_back(predict(rm, off, tag));
    endtask

    task automatic do_idle(string tag);
        @(negedge clk);
        drive(0, 0, 0, 0);
        sb_q.push_back(quiet(tag));
    endtask

    task automatic do_load(logic [15:0] s, logic [31:0] b, logic [19:0] l, bit g, string tag);
        @(negedge clk);
        drive(1, 0, 0, 0);
        seg_sel_i = s; seg_base_i = b; seg_limit_i = l; seg_gran_i = g;
        sb_q.push_back(quiet(tag));
        m_sel = s; m_base = b; m_lim = l; m_gran = g;
    endtask

    // load and request in the same cycle: request sees the old segment
    task automatic do_load_req(logic [15:0] s, logic [31:0] b, logic [19:0] l, bit g,
                               logic [31:0] off, string tag);
        @(negedge clk);
        drive(1, 1, 0, off);
        seg_sel_i = s; seg_base_i = b; seg_limit_i = l; seg_gran_i = g;
        sb_q.push_back(predict(0, off, tag));
        m_sel = s; m_base = b; m_lim = l; m_gran = g;
    endtask

    // monitor: outputs settle just after the edge that sampled the request
    always @(posedge clk) begin
        #1;
        if (sb_q.size() != 0) begin
            exp_t x;
            x = sb_q.pop_front();
            checks++;
            if (rsp_valid_o !== x.v || rsp_fault_o !== x.f ||
                rsp_addr_o !== x.a || rsp_err_o !== x.e) begin
                failures++;
                $display("FAIL %s: got v=%0b f=%0b a=%h e=%h exp v=%0b f=%0b a=%h e=%h",
                         x.tag, rsp_valid_o, rsp_fault_o, rsp_addr_o, rsp_err_o,
                         x.v, x.f, x.a, x.e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        drive(0, 0, 0, 0);
        seg_sel_i = 0; seg_base_i = 0; seg_limit_i = 0; seg_gran_i = 0;
        repeat (3) @(negedge clk);
        drive(0, 1, 1, 32'h1234);         // activity during reset must not show
        @(negedge clk);
        checks++;
        if (rsp_valid_o !== 0 || rsp_fault_o !== 0 || rsp_addr_o !== 0 || rsp_err_o !== 0) begin
            failures++;
            $display("FAIL R8 reset: got v=%0b f=%0b a=%h e=%h exp all zero",
                     rsp_valid_o, rsp_fault_o, rsp_addr_o, rsp_err_o);
        end
        drive(0, 0, 0, 0);
        rst_n = 1;

        // byte granular segment
        do_load(16'h0023, 32'h1000_0000, 20'h00FFF, 0, "R9 load quiet");
        do_req(0, 32'h0, "R1 base+0");
        do_req(0, 32'h0000_0FFF, "R2 offset at limit");
        do_req(0, 32'h0000_1000, "R6 limit+1 fault code");
        do_idle("R7 quiet after fault");

        // wrap modulo 2^32
        do_load(16'h004A, 32'hFFFF_F100, 20'h00FFF, 0, "R9 load quiet");
        do_req(0, 32'h0000_0FF0, "R1 wrap");

        // 4 KiB granularity
        do_load(16'h0010, 32'h0002_0000, 20'h00001, 1, "R3 load");
        do_req(0, 32'h0000_1FFF, "R3 scaled limit edge");
        do_req(0, 32'h0000_2000, "R3 scaled limit+1");
        do_load(16'h0018, 32'h0, 20'hFFFFF, 1, "R3 load full");
        do_req(0, 32'hFFFF_FFFF, "R3 4GiB top");

        // null selector
        do_load(16'h0003, 32'h0000_5000, 20'hFFFFF, 0, "R5 null load no fault");
        do_idle("R5 null held no fault");
        do_req(0, 32'h0, "R5 null access");
        do_req(1, 32'h0000_0010, "R4 real with null");

        // real mode
        do_load(16'h1234, 32'h0000_0009, 20'h00000, 0, "R9 load");
        do_req(1, 32'h0000_0005, "R4 real shift");
        do_req(1, 32'h0010_0000, "R4 real past limit");
        do_req(0, 32'h0000_0001, "R6 fault code rpl cleared");

        // same-cycle load
        do_load_req(16'h0023, 32'h1000_0000, 20'h00FFF, 0, 32'h0, "R9 old segment used");
        do_req(0, 32'h0000_0010, "R9 new segment used");
        do_req(0, 32'h0000_0020, "R7 back to back");
        do_idle("R7 quiet");
        do_idle("R7 quiet drain");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule